// File: doc/BRIEF.md
# Two-Operand ALU with Condition-Flag Compare

This block is the execute-stage arithmetic unit of a small 16-bit load/store core. Each cycle it may accept one operation, named by a 6-bit code, with two register operands: a source and a destination. The top bit of the code picks one of two classes. A clear top bit selects a register-writing operation: add, subtract, bitwise logic, complement, or a one-bit shift. Its result goes back to the destination register. A set top bit selects a compare. A compare writes no register. It only produces a new value for the 1-bit condition flag, which later conditional instructions test.

All outputs are registered. They describe the operation accepted one clock earlier. The write-back enable, the flag-update enable and the illegal-code indication are mutually exclusive, and all three are low after a cycle with no valid input. The surrounding pipeline owns the register file and the flag register. It uses the enables to commit the results.

Top module: `alu_cflag_core`

## Requirements
- R1: While reset is asserted, and until the first accepted operation, every output is zero.
- R2: An operation accepted on a rising edge with `in_valid` high appears on the outputs right after the next rising edge. After an edge where `in_valid` was low, `out_wr_en`, `out_flag_we`, `out_illegal`, `out_flag` and `out_result` are all zero.
- R3: Code 000000 gives destination plus source, and code 000001 gives destination minus source. Both wrap modulo 2^16.
- R4: Code 000010 gives source AND destination, 000011 gives OR, and 000100 gives XOR. Code 000101 gives the bitwise complement of the source.
- R5: Code 000110 shifts the source left by exactly one bit and inserts a zero at bit 0.
- R6: Code 000111 shifts the source right by one bit and inserts a zero at bit 15. Code 001000 shifts it right by one bit and copies the old bit 15 into bit 15.
- R7: Every listed code with bit 5 clear (000000 to 001000) sets `out_wr_en`. It never sets `out_flag_we`.
- R8: Every listed code with bit 5 set (100000 to 100101) sets `out_flag_we`, keeps `out_wr_en` low and drives `out_result` to zero.
- R9: Code 100000 sets the flag when source equals destination. Code 100001 sets it when they differ.
- R10: Code 100010 sets the flag when source > destination, and code 100011 sets it when source < destination. Both compares are unsigned over 16 bits.
- R11: Code 100100 sets the flag when the source is zero, and code 100101 sets it when the source is nonzero. The destination operand has no effect on either.
- R12: Any other code (001001 to 011111, 100110 to 111111) asserts `out_illegal`. It leaves `out_wr_en`, `out_flag_we`, `out_flag` and `out_result` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 6 | Operation code; bit 5 selects compare |
| src_opd | input | 16 | Source operand |
| dst_opd | input | 16 | Destination operand |
| out_result | output | 16 | Value to write to the destination register |
| out_wr_en | output | 1 | Destination register write enable |
| out_flag_we | output | 1 | Condition flag update enable |
| out_flag | output | 1 | New condition flag value |
| out_illegal | output | 1 | The accepted code is not defined |

## Verification
All state in the block sits in the single output register stage. A wrong class decode or a stale register therefore shows on the very next edge after the faulty operation. It appears as a wrong enable combination, or as an enable that outlives an idle cycle. An operand swap or a sign error shows on the same edge, but only for inputs that can tell the cases apart. For this reason the subtract, ordering and shift checks use asymmetric operands and values with bit 15 set. The illegal-code checks sweep every undefined code, so a decode hole cannot hide in an untested value.

// File: rtl/alu_cflag_pkg.sv
`timescale 1ns/1ps
package alu_cflag_pkg;

  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 6'b000000,
    OP_SUB = 6'b000001,
    OP_AND = 6'b000010,
    OP_OR  = 6'b000011,
    OP_XOR = 6'b000100,
    OP_NOT = 6'b000101,
    OP_SHL = 6'b000110,
    OP_SHR = 6'b000111,
    OP_ASR = 6'b001000,
    OP_CEQ = 6'b100000,
    OP_CNE = 6'b100001,
    OP_CGT = 6'b100010,
    OP_CLT = 6'b100011,
    OP_CEZ = 6'b100100,
    OP_CNZ = 6'b100101
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_IDLE  = 2'd0,
    CLS_WRITE = 2'd1,
    CLS_FLAG  = 2'd2,
    CLS_BAD   = 2'd3
  } op_class_e;

endpackage

// File: rtl/alu_cflag_rst_sync.sv
`timescale 1ns/1ps
module alu_cflag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_cflag_decode.sv
`timescale 1ns/1ps
module alu_cflag_decode
  import alu_cflag_pkg::*;
(
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  output op_class_e       cls
);
  always_comb begin
    cls = CLS_IDLE;
    if (valid) begin
      case (op)
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
        OP_NOT, OP_SHL, OP_SHR, OP_ASR:           cls = CLS_WRITE;
        OP_CEQ, OP_CNE, OP_CGT, OP_CLT,
        OP_CEZ, OP_CNZ:                           cls = CLS_FLAG;
        default:                                  cls = CLS_BAD;
      endcase
    end
  end
endmodule

// File: rtl/alu_cflag_arith.sv
`timescale 1ns/1ps
module alu_cflag_arith
  import alu_cflag_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  output logic [WIDTH-1:0] res
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] diff_w;

  assign sum_w  = dst + src;
  assign diff_w = dst - src;

  always_comb begin
    res = '0;
    case (op)
      OP_ADD: res = sum_w;
      OP_SUB: res = diff_w;
      OP_AND: res = src & dst;
      OP_OR:  res = src | dst;
      OP_XOR: res = src ^ dst;
      OP_NOT: res = ~src;
      OP_SHL: res = {src[MSB-1:0], 1'b0};
      OP_SHR: res = {1'b0, src[MSB:1]};
      OP_ASR: res = {src[MSB], src[MSB:1]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_cflag_cmp.sv
`timescale 1ns/1ps
module alu_cflag_cmp
  import alu_cflag_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  output logic             flag
);
  logic src_gt;
  logic src_lt;
  logic same;
  logic src_zero;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign src_gt = $signed(src) > $signed(dst);
      assign src_lt = $signed(src) < $signed(dst);
    end else begin : g_unsigned
      assign src_gt = src > dst;
      assign src_lt = src < dst;
    end
  endgenerate

  assign same     = (src == dst);
  assign src_zero = (src == '0);

  always_comb begin
    flag = 1'b0;
    case (op)
      OP_CEQ: flag = same;
      OP_CNE: flag = ~same;
      OP_CGT: flag = src_gt;
      OP_CLT: flag = src_lt;
      OP_CEZ: flag = src_zero;
      OP_CNZ: flag = ~src_zero;
      default: flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cflag_core.sv
`timescale 1ns/1ps
module alu_cflag_core
  import alu_cflag_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [5:0]       op_code,
  input  logic [WIDTH-1:0] src_opd,
  input  logic [WIDTH-1:0] dst_opd,
  output logic [WIDTH-1:0] out_result,
  output logic             out_wr_en,
  output logic             out_flag_we,
  output logic             out_flag,
  output logic             out_illegal
);
  logic             rst_sync_n;
  op_class_e        cls;
  logic [WIDTH-1:0] arith_res;
  logic             cmp_flag;

  logic [WIDTH-1:0] result_d, result_q;
  logic             wr_d, wr_q;
  logic             fwe_d, fwe_q;
  logic             flag_d, flag_q;
  logic             ill_d, ill_q;
  logic             busy_q;
  logic             stage_en;

  alu_cflag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alu_cflag_decode u_dec (
    .valid (in_valid),
    .op    (op_code),
    .cls   (cls)
  );

  alu_cflag_arith #(.WIDTH(WIDTH)) u_arith (
    .op  (op_code),
    .src (src_opd),
    .dst (dst_opd),
    .res (arith_res)
  );

  alu_cflag_cmp #(.WIDTH(WIDTH), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
    .op   (op_code),
    .src  (src_opd),
    .dst  (dst_opd),
    .flag (cmp_flag)
  );

  // next state of the output stage
  always_comb begin
    result_d = '0;
    wr_d     = 1'b0;
    fwe_d    = 1'b0;
    flag_d   = 1'b0;
    ill_d    = 1'b0;
    case (cls)
      CLS_WRITE: begin
        result_d = arith_res;
        wr_d     = 1'b1;
      end
      CLS_FLAG: begin
        fwe_d  = 1'b1;
        flag_d = cmp_flag;
      end
      CLS_BAD:  ill_d = 1'b1;
      default:  ;
    endcase
  end

  // load on a new operation, or once more to clear after the last one
  assign stage_en = in_valid | busy_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q   <= 1'b0;
      result_q <= '0;
      wr_q     <= 1'b0;
      fwe_q    <= 1'b0;
      flag_q   <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      busy_q <= in_valid;
      if (stage_en) begin
        result_q <= result_d;
        wr_q     <= wr_d;
        fwe_q    <= fwe_d;
        flag_q   <= flag_d;
        ill_q    <= ill_d;
      end
    end
  end

  assign out_result  = result_q;
  assign out_wr_en   = wr_q;
  assign out_flag_we = fwe_q;
  assign out_flag    = flag_q;
  assign out_illegal = ill_q;
endmodule

// File: rtl/alu_cflag_checker.sv
`timescale 1ns/1ps
module alu_cflag_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [5:0]       op_code,
  input logic [WIDTH-1:0] src_opd,
  input logic [WIDTH-1:0] dst_opd,
  input logic [WIDTH-1:0] out_result,
  input logic             out_wr_en,
  input logic             out_flag_we,
  input logic             out_flag,
  input logic             out_illegal
);
  // R2: nothing is reported after an idle cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_wr_en && !out_flag_we && !out_illegal && !out_flag));

  // R7, R8, R12: the three indications never overlap
  a_r7_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_wr_en, out_flag_we, out_illegal}));

  // R8: a compare never requests a register write
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code[5]) |=> (!out_wr_en && out_result == '0));

  // R7: low-half codes never touch the flag
  a_r7_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_code[5]) |=> !out_flag_we);

  // R12: an illegal report carries no data
  a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_result == '0 && !out_flag));

  // R11: zero tests depend only on the source
  a_r11_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 6'b100100) |=> (out_flag == ($past(src_opd) == '0)));
endmodule

bind alu_cflag_core alu_cflag_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op_code     (op_code),
  .src_opd     (src_opd),
  .dst_opd     (dst_opd),
  .out_result  (out_result),
  .out_wr_en   (out_wr_en),
  .out_flag_we (out_flag_we),
  .out_flag    (out_flag),
  .out_illegal (out_illegal)
);

// File: tb/sim_alu_cflag_core.sv
`timescale 1ns/1ps
module sim_alu_cflag_core;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [5:0]  op_code;
  logic [15:0] src_opd;
  logic [15:0] dst_opd;
  logic [15:0] out_result;
  logic        out_wr_en;
  logic        out_flag_we;
  logic        out_flag;
  logic        out_illegal;

  int checks;
  int errors;
  bit done;

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic        fwe;
    logic        flag;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  alu_cflag_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_opd(src_opd), .dst_opd(dst_opd), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flag_we(out_flag_we), .out_flag(out_flag),
    .out_illegal(out_illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic exp_t model(bit v, logic [5:0] op, logic [15:0] s,
                                 logic [15:0] d, string tag);
    exp_t e;
    e.res = '0; e.wr = 0; e.fwe = 0; e.flag = 0; e.ill = 0; e.tag = tag;
    if (v) begin
      case (op)
        6'b000000: begin e.wr = 1; e.res = d + s; end
        6'b000001: begin e.wr = 1; e.res = d - s; end
        6'b000010: begin e.wr = 1; e.res = s & d; end
        6'b000011: begin e.wr = 1; e.res = s | d; end
        6'b000100: begin e.wr = 1; e.res = s ^ d; end
        6'b000101: begin e.wr = 1; e.res = ~s; end
        6'b000110: begin e.wr = 1; e.res = s << 1; end
        6'b000111: begin e.wr = 1; e.res = s >> 1; end
        6'b001000: begin e.wr = 1; e.res = {s[15], s[15:1]}; end
        6'b100000: begin e.fwe = 1; e.flag = (s == d); end
        6'b100001: begin e.fwe = 1; e.flag = (s != d); end
        6'b100010: begin e.fwe = 1; e.flag = (s > d); end
        6'b100011: begin e.fwe = 1; e.flag = (s < d); end
        6'b100100: begin e.fwe = 1; e.flag = (s == 0); end
        6'b100101: begin e.fwe = 1; e.flag = (s != 0); end
        default:   e.ill = 1;
      endcase
    end
    return e;
  endfunction

  // driver: present inputs at the falling edge and queue the expectation
  task automatic drive(bit v, logic [5:0] op, logic [15:0] s, logic [15:0] d,
                       string tag);
    @(negedge clk);
    in_valid = v; op_code = op; src_opd = s; dst_opd = d;
    sb_q.push_back(model(v, op, s, d, tag));
  endtask

  // monitor: outputs of an operation are stable mid-high-phase after the edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (out_result !== e.res || out_wr_en !== e.wr || out_flag_we !== e.fwe ||
          out_flag !== e.flag || out_illegal !== e.ill) begin
        errors++;
        $display("FAIL %s: got res=%h wr=%b fwe=%b flag=%b ill=%b exp res=%h wr=%b fwe=%b flag=%b ill=%b",
                 e.tag, out_result, out_wr_en, out_flag_we, out_flag, out_illegal,
                 e.res, e.wr, e.fwe, e.flag, e.ill);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; in_valid = 0; op_code = '0; src_opd = '0; dst_opd = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({out_result, out_wr_en, out_flag_we, out_flag, out_illegal} !== '0) begin
      errors++;
      $display("FAIL R1: got res=%h wr=%b fwe=%b flag=%b ill=%b exp all zero",
               out_result, out_wr_en, out_flag_we, out_flag, out_illegal);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    checks++;
    if ({out_result, out_wr_en, out_flag_we, out_flag, out_illegal} !== '0) begin
      errors++;
      $display("FAIL R1: after release got res=%h exp 0000", out_result);
    end

    // R3 arithmetic with wrap
    drive(1, 6'b000000, 16'h1234, 16'h0F0F, "R3 add");
    drive(1, 6'b000000, 16'h0001, 16'hFFFF, "R3 add wrap");
    drive(1, 6'b000001, 16'h0003, 16'h0010, "R3 sub dst-src");
    drive(1, 6'b000001, 16'h0001, 16'h0000, "R3 sub wrap");
    drive(0, 6'b000000, 16'h5555, 16'h5555, "R2 idle after op");
    // R4 logic
    drive(1, 6'b000010, 16'hF0F0, 16'h3C3C, "R4 and");
    drive(1, 6'b000011, 16'hF0F0, 16'h3C3C, "R4 or");
    drive(1, 6'b000100, 16'hF0F0, 16'h3C3C, "R4 xor");
    drive(1, 6'b000101, 16'h00FF, 16'h1234, "R4 not of source");
    // R5, R6 shifts
    drive(1, 6'b000110, 16'h8001, 16'h0000, "R5 shl");
    drive(1, 6'b000111, 16'h8001, 16'hFFFF, "R6 shr zero fill");
    drive(1, 6'b001000, 16'h8002, 16'h0000, "R6 asr sign fill");
    drive(1, 6'b001000, 16'h4002, 16'h0000, "R6 asr positive");
    // R7: every low-half code writes
    for (int k = 0; k < 9; k++)
      drive(1, 6'(k), 16'hA5C3, 16'h0F71, "R7 low-half class");
    drive(0, 6'b100000, 16'h0, 16'h0, "R2 idle");
    // R8, R9 equality
    drive(1, 6'b100000, 16'h7777, 16'h7777, "R9 eq true");
    drive(1, 6'b100000, 16'h7777, 16'h7776, "R9 eq false");
    drive(1, 6'b100001, 16'h7777, 16'h7776, "R9 ne true");
    drive(1, 6'b100001, 16'h0000, 16'h0000, "R9 ne false");
    // R10 unsigned ordering
    drive(1, 6'b100010, 16'h8000, 16'h7FFF, "R10 gt unsigned");
    drive(1, 6'b100010, 16'h1000, 16'h1000, "R10 gt equal");
    drive(1, 6'b100010, 16'h0001, 16'h0002, "R10 gt false");
    drive(1, 6'b100011, 16'h7FFF, 16'h8000, "R10 lt unsigned");
    drive(1, 6'b100011, 16'h0002, 16'h0001, "R10 lt false");
    drive(1, 6'b100011, 16'h1000, 16'h1000, "R10 lt equal");
    // R11 zero tests with a nonzero dst
    drive(1, 6'b100100, 16'h0000, 16'hBEEF, "R11 ez true");
    drive(1, 6'b100100, 16'h0100, 16'h0000, "R11 ez false");
    drive(1, 6'b100101, 16'h0000, 16'hFFFF, "R11 nz false");
    drive(1, 6'b100101, 16'h8000, 16'h0000, "R11 nz true");
    // R8: compares keep result zero even after a write
    drive(1, 6'b000011, 16'hFFFF, 16'h0000, "R7 or before compare");
    drive(1, 6'b100000, 16'hFFFF, 16'hFFFF, "R8 compare no write");
    // R12: sweep every undefined code
    for (int k = 9; k < 32; k++)
      drive(1, 6'(k), 16'hFFFF, 16'h1234, "R12 illegal low");
    for (int k = 38; k < 64; k++)
      drive(1, 6'(k), 16'h0000, 16'hFFFF, "R12 illegal high");
    drive(0, 6'b111111, 16'h0, 16'h0, "R2 idle after illegal");
    drive(0, 6'b000000, 16'h0, 16'h0, "R2 idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule